// File: doc/BRIEF.md
# Four-State Interrupt Mode Sequencer

This block keeps track of which of four execution modes a processor is in: the run mode for ordinary program work, the serve mode where an interrupt handler does its work, the triage mode that analyses ordinary interrupts, and the fault mode that analyses machine-condition interrupts (machine check, scratch-pad parity, power failure). Each mode drives its own register-bank select line, so software in one mode never disturbs the registers of another.

Interrupt sources raise one-cycle set pulses. The block latches them as pending, filters them through a programmable enable mask that belongs to the current mode, and picks the winner by fixed priority. A winner of the machine class sends the processor to fault mode. An ordinary winner sends it to triage mode. Before either entry, the mode and service identifier being left are pushed onto a small return stack. Triage and fault software signal the end of their analysis with a link pulse, which moves the processor to serve mode. A done pulse in serve mode pops the stack and resumes whichever mode was interrupted last.

Top module: `intr_mode_seq`

## Requirements
- R1: After reset the mode is run (code 0), every enable mask is zero, so pending requests are held but not taken, the return stack is empty and the overflow flag is low.
- R2: A pending ordinary request that is enabled in run or serve mode is taken two clock edges after its set pulse. The mode becomes triage (code 2), and ack_o is high for that one cycle with ack_id_o equal to the request's identifier.
- R3: A pending machine-class request that is enabled in run, serve or triage mode is taken into fault mode (code 3), with the same acknowledge timing as R2.
- R4: Identifiers are 0..N_MC-1 for mc_set_i bits 0.. and N_MC+j for ord_set_i bit j. The lowest enabled pending identifier wins, so every machine cause outranks every ordinary cause. The remaining requests are taken later in the same order.
- R5: Each mode has its own enable mask, where bit k enables identifier k. It is written with en_we_i, en_sel_i (the mode code) and en_val_i, and it takes effect at the next edge. A request that is disabled stays pending and is taken once it is enabled.
- R6: A link pulse in triage or fault mode moves the processor to serve mode (code 1) without changing svc_id_o. A link pulse in run or serve mode has no effect.
- R7: A done pulse in serve mode pops the return stack and restores the saved mode and svc_id_o. A done pulse in any other mode has no effect.
- R8: bank_sel_o is one-hot, with bit m set when the mode code is m.
- R9: The return stack holds 4 entries. An interrupt that would push a fifth entry is refused and stays pending, the mode is unchanged, and nest_ovf_o goes high and stays high until reset.
- R10: When an interrupt is taken on the same edge as a link or done pulse, the interrupt wins and the pulse is dropped.
- R11: No interrupt is taken in fault mode, and ordinary requests are not taken in triage mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_set_i | input | N_ORD | One-cycle set pulses for ordinary causes |
| mc_set_i | input | N_MC | One-cycle set pulses for machine-condition causes |
| en_we_i | input | 1 | Enable mask write strobe |
| en_sel_i | input | 2 | Mode code whose mask is written |
| en_val_i | input | N_MC+N_ORD | New mask value, bit k enables identifier k |
| link_i | input | 1 | Analysis finished, hand off to serve mode |
| done_i | input | 1 | Servicing finished, return to the interrupted mode |
| mode_o | output | 2 | Active mode: 0 run, 1 serve, 2 triage, 3 fault |
| bank_sel_o | output | 4 | One-hot register-bank select |
| svc_id_o | output | IDW | Identifier currently being serviced |
| ack_o | output | 1 | One-cycle acknowledge on interrupt entry |
| ack_id_o | output | IDW | Identifier acknowledged |
| nest_ovf_o | output | 1 | Sticky return-stack overflow flag |

## Verification
The bench first holds a request while its mask is closed and then opens the mask. A design that drops masked requests would never leave run mode. It nests four deep, through two serve-mode preemptions and a machine cause taken in triage, and then lets a further machine cause arrive on a full stack. A design that overwrites the stack would later return to the wrong mode or identifier as the stack unwinds, and one that fails to refuse the entry would leave serve mode at once. The bench also places a take on the same edge as a link and as a done pulse. A design that honours the pulse first would show serve mode or a popped mode where fault or triage belongs.

// File: rtl/intr_mode_pkg.sv
package intr_mode_pkg;
  localparam int MODE_W = 2;
  localparam int N_MODES = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 2'd0,
    MODE_SERVE  = 2'd1,
    MODE_TRIAGE = 2'd2,
    MODE_FAULT  = 2'd3
  } mode_e;
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins
  function automatic logic [IW:0] lowest_set(input logic [N-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0] pick;
  assign pick    = lowest_set(cand_i);
  assign found_o = pick[IW];
  assign idx_o   = pick[IW-1:0];

  // R4
  pick_valid_chk: assert final (!found_o || cand_i[idx_o]);
endmodule

// File: rtl/intr_en_bank.sv
module intr_en_bank
  import intr_mode_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [MODE_W-1:0] sel_i,
  input  logic [NB-1:0]     val_i,
  input  logic [MODE_W-1:0] cur_i,
  output logic [NB-1:0]     en_cur_o
);
  logic [NB-1:0] en_r [N_MODES];

  for (genvar g = 0; g < N_MODES; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)                              en_r[g] <= '0;
      else if (we_i && sel_i == MODE_W'(g))    en_r[g] <= val_i;
    end
  end

  assign en_cur_o = en_r[cur_i];
endmodule

// File: rtl/intr_ret_stack.sv
module intr_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push_i) begin
      cnt <= cnt + CW'(1);
    end else if (pop_i) begin
      cnt <= cnt - CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (push_i && cnt == CW'(g))        mem[g] <= din_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CW'(i + 1)) top_o = mem[i];
    end
  end

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o));
  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o));
endmodule

// File: rtl/intr_mode_seq.sv
module intr_mode_seq
  import intr_mode_pkg::*;
#(
  parameter int N_ORD     = 6,
  parameter int N_MC      = 2,
  parameter int NEST      = 4,
  parameter int N_TOT     = N_MC + N_ORD,
  parameter int IDW       = $clog2(N_TOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ORD-1:0] ord_set_i,
  input  logic [N_MC-1:0]  mc_set_i,
  input  logic             en_we_i,
  input  logic [1:0]       en_sel_i,
  input  logic [N_TOT-1:0] en_val_i,
  input  logic             link_i,
  input  logic             done_i,
  output logic [1:0]       mode_o,
  output logic [3:0]       bank_sel_o,
  output logic [IDW-1:0]   svc_id_o,
  output logic             ack_o,
  output logic [IDW-1:0]   ack_id_o,
  output logic             nest_ovf_o
);
  localparam int SW = MODE_W + IDW;

  mode_e            mode_q;
  logic [IDW-1:0]   svc_q;
  logic [N_TOT-1:0] pend_q, en_cur, clr_vec;
  logic             win_found, win_mc, class_ok, take_go, take_blk;
  logic [IDW-1:0]   win_idx;
  logic             link_go, done_go;
  logic [SW-1:0]    st_top;
  logic             st_full, st_empty;

  intr_en_bank #(.NB(N_TOT)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(en_we_i), .sel_i(en_sel_i),
    .val_i(en_val_i), .cur_i(mode_q), .en_cur_o(en_cur)
  );

  intr_prio_pick #(.N(N_TOT), .IW(IDW)) u_pick (
    .cand_i(pend_q & en_cur), .found_o(win_found), .idx_o(win_idx)
  );

  // class of the winner and whether the current mode may take it
  assign win_mc   = (win_idx < IDW'(N_MC));
  assign class_ok = win_mc ? (mode_q != MODE_FAULT)
                           : (mode_q == MODE_RUN || mode_q == MODE_SERVE);
  assign take_go  = win_found && class_ok && !st_full;
  assign take_blk = win_found && class_ok && st_full;
  assign link_go  = !take_go && link_i &&
                    (mode_q == MODE_TRIAGE || mode_q == MODE_FAULT);
  assign done_go  = !take_go && done_i && mode_q == MODE_SERVE && !st_empty;

  intr_ret_stack #(.DEPTH(NEST), .W(SW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(take_go), .pop_i(done_go),
    .din_i({mode_q, svc_q}), .top_o(st_top),
    .full_o(st_full), .empty_o(st_empty)
  );

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < N_TOT; i++) begin
      if (take_go && win_idx == IDW'(i)) clr_vec[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      mode_q     <= MODE_RUN;
      svc_q      <= '0;
      ack_o      <= 1'b0;
      ack_id_o   <= '0;
      nest_ovf_o <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~clr_vec) | {ord_set_i, mc_set_i};
      ack_o      <= take_go;
      nest_ovf_o <= nest_ovf_o | take_blk;
      if (take_go) begin
        mode_q   <= win_mc ? MODE_FAULT : MODE_TRIAGE;
        svc_q    <= win_idx;
        ack_id_o <= win_idx;
      end else if (link_go) begin
        mode_q <= MODE_SERVE;
      end else if (done_go) begin
        mode_q <= mode_e'(st_top[SW-1:IDW]);
        svc_q  <= st_top[IDW-1:0];
      end
    end
  end

  assign mode_o     = mode_q;
  assign svc_id_o   = svc_q;
  assign bank_sel_o = 4'b0001 << mode_q;

  // R2
  ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (mode_q == MODE_TRIAGE || mode_q == MODE_FAULT));
  // R2
  take_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_go |=> (ack_o && ack_id_o == svc_id_o));
  // R3
  mc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_go && win_mc) |=> mode_q == MODE_FAULT);
  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_FAULT |-> !take_go);
  // R6
  link_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_go |=> (mode_q == MODE_SERVE && $stable(svc_id_o)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_ovf_o |=> nest_ovf_o);
  // R8
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_sel_o) == 1);
endmodule

// File: tb/sim_intr_mode_seq.sv
`timescale 1ns/1ps
module sim_intr_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ord_set = '0;
  logic [1:0] mc_set = '0;
  logic       en_we = 1'b0;
  logic [1:0] en_sel = '0;
  logic [7:0] en_val = '0;
  logic       link = 1'b0, done = 1'b0;
  logic [1:0] mode;
  logic [3:0] bank;
  logic [2:0] svc_id, ack_id;
  logic       ack, ovf;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  intr_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .ord_set_i(ord_set), .mc_set_i(mc_set),
    .en_we_i(en_we), .en_sel_i(en_sel), .en_val_i(en_val),
    .link_i(link), .done_i(done), .mode_o(mode), .bank_sel_o(bank),
    .svc_id_o(svc_id), .ack_o(ack), .ack_id_o(ack_id), .nest_ovf_o(ovf)
  );

  typedef struct {
    logic [1:0] m;
    logic [2:0] id;
    logic       a;
    logic       e;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // monitor: compares outputs half a cycle after each edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk({it.tag, " mode"}, mode, it.m);
      chk("R8 bank one-hot", bank, 4'b0001 << it.m);
      chk({it.tag, " ack"}, ack, it.a);
      chk({it.tag, " overflow flag (R9)"}, ovf, it.e);
      if (it.m != 2'd0) chk({it.tag, " svc id"}, svc_id, it.id);
      if (it.a) chk({it.tag, " ack id"}, ack_id, it.id);
    end
  end

  // driver: applies stimulus for one edge, queues the expected outcome
  task automatic step(input logic [5:0] o, input logic [1:0] mc,
                      input bit lk, input bit dn, input bit we,
                      input logic [1:0] sel, input logic [7:0] val,
                      input logic [1:0] em, input logic [2:0] eid,
                      input bit ea, input bit ee, input string tag);
    ord_set = o; mc_set = mc; link = lk; done = dn;
    en_we = we; en_sel = sel; en_val = val;
    @(posedge clk); #1;
    q.push_back('{em, eid, ea, ee, tag});
    ord_set = '0; mc_set = '0; link = 1'b0; done = 1'b0; en_we = 1'b0;
  endtask

  task automatic idle(input logic [1:0] em, input logic [2:0] eid,
                      input bit ea, input bit ee, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, em, eid, ea, ee, tag);
  endtask
  task automatic ord(input logic [5:0] o, input logic [1:0] em,
                     input logic [2:0] eid, input bit ee, input string tag);
    step(o, 0, 0, 0, 0, 0, 0, em, eid, 0, ee, tag);
  endtask
  task automatic mcp(input logic [1:0] mc, input logic [1:0] em,
                     input logic [2:0] eid, input bit ea, input bit ee,
                     input string tag);
    step(0, mc, 0, 0, 0, 0, 0, em, eid, ea, ee, tag);
  endtask
  task automatic lnk(input logic [1:0] em, input logic [2:0] eid,
                     input bit ea, input bit ee, input string tag);
    step(0, 0, 1, 0, 0, 0, 0, em, eid, ea, ee, tag);
  endtask
  task automatic dne(input logic [5:0] o, input logic [1:0] em,
                     input logic [2:0] eid, input bit ea, input bit ee,
                     input string tag);
    step(o, 0, 0, 1, 0, 0, 0, em, eid, ea, ee, tag);
  endtask
  task automatic enw(input logic [1:0] sel, input logic [1:0] em,
                     input logic [2:0] eid, input string tag);
    step(0, 0, 0, 0, 1, sel, 8'hFF, em, eid, 0, 0, tag);
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (R1..all): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // modes: 0 run, 1 serve, 2 triage, 3 fault
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    q.push_back('{2'd0, 3'd0, 1'b0, 1'b0, "R1 reset"});
    ord(6'b000001, 0, 0, 0, "R1 masks closed");
    idle(0, 0, 0, 0, "R5 masked request held");
    idle(0, 0, 0, 0, "R5 masked request held");
    enw(2'd0, 0, 0, "R5 mask write");
    idle(2, 2, 1, 0, "R5 pending taken, R2 entry");
    idle(2, 2, 0, 0, "R2 ack one cycle");
    enw(2'd1, 2, 2, "R5");
    enw(2'd2, 2, 2, "R5");
    enw(2'd3, 2, 2, "R5");
    dne(0, 2, 2, 0, 0, "R7 done ignored in triage");
    lnk(1, 2, 0, 0, "R6 link to serve");
    ord(6'b001010, 1, 2, 0, "R4 two requests");
    idle(2, 3, 1, 0, "R4 lowest id first");
    idle(2, 3, 0, 0, "R11 ordinary not taken in triage");
    lnk(1, 3, 0, 0, "R6");
    idle(2, 5, 1, 0, "R4 next in order");
    mcp(2'b10, 2, 5, 0, 0, "R3 machine request");
    idle(3, 1, 1, 0, "R3 fault from triage");
    mcp(2'b01, 3, 1, 0, 0, "R11");
    idle(3, 1, 0, 0, "R11 nothing taken in fault");
    lnk(1, 1, 0, 0, "R6 fault to serve");
    idle(1, 1, 0, 1, "R9 fifth entry refused");
    dne(0, 2, 5, 0, 1, "R7 pop after refusal");
    idle(3, 0, 1, 1, "R9 refused request later taken");
    lnk(1, 0, 0, 1, "R6");
    dne(0, 2, 5, 0, 1, "R7 unwind");
    lnk(1, 5, 0, 1, "R6");
    dne(0, 1, 3, 0, 1, "R7 unwind");
    dne(0, 1, 2, 0, 1, "R7 unwind");
    dne(0, 0, 0, 0, 1, "R7 back to run");
    lnk(0, 0, 0, 1, "R6 link ignored in run");
    dne(0, 0, 0, 0, 1, "R7 done ignored in run");
    ord(6'b010000, 0, 0, 1, "R2");
    idle(2, 6, 1, 1, "R2 entry");
    mcp(2'b01, 2, 6, 0, 1, "R10");
    lnk(3, 0, 1, 1, "R10 take beats link");
    lnk(1, 0, 0, 1, "R6");
    dne(6'b100000, 2, 6, 0, 1, "R7");
    lnk(1, 6, 0, 1, "R6");
    dne(0, 2, 7, 1, 1, "R10 take beats done");
    lnk(1, 7, 0, 1, "R6");
    dne(0, 1, 6, 0, 1, "R7");
    dne(0, 0, 0, 0, 1, "R7 back to run");
    @(negedge clk); #1;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule